// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block supervises a processor through a single strobe line. The processor must produce a falling edge on the strobe often enough. If no falling edge arrives within the selected timeout, the block drives its active-low reset output low for a programmable number of clock cycles and then releases it. After the release, supervision starts again from zero.

The timeout is set in clock cycles by a base-period input. A mode-select line picks one of two scales. In normal mode the timeout is the base period. In extended mode it is 128 times the base period. Any change on the mode-select line, in either direction, restarts the count. A base period of zero switches fault detection off.

The strobe and mode-select lines are asynchronous to the clock and are synchronised inside the block. An asynchronous power-on reset starts the block with its reset output already asserted for one full hold period.

Top module: `wdt_top`

## Requirements
- R1: While the reset output is high and no strobe or mode edge arrives, the output goes low after exactly L cycles, where L is the timeout latched at the last counter clear.
- R2: The strobe is passed through two synchroniser flops. A registered 1 followed by a registered 0 is a falling edge, and it clears the counter. With no further edges, the reset output falls L+3 cycles after the strobe input drops.
- R3: A rising or a falling change on the mode-select input clears the counter. The reset output then falls L+3 cycles after the change, with L taken in the newly selected mode.
- R4: While the reset output is low, the counter is held at zero. Strobe and mode edges in that time change neither the hold length nor the next timeout.
- R5: The counter starts counting in the first cycle after the reset output rises. With no edges, the output therefore stays high for exactly L cycles.
- R6: L equals the base period when mode-select is 0, and 128 times the base period when mode-select is 1.
- R7: A base period of 0 latched at a clear disables faults. The reset output then stays high whatever the strobe and mode lines do.
- R8: A fault holds the reset output low for exactly max(hold length, 1) cycles, after which the output is released.
- R9: While the power-on reset is low, the reset output is low. After the power-on reset is released, the output stays low for max(hold length, 1) cycles.
- R10: A change on the base-period input has no effect until the next counter clear. The timeout that is already running keeps its old L.
- R11: Strobe falling edges spaced fewer than L cycles apart keep the reset output high indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdi | input | 1 | Processor strobe; a falling edge restarts the timeout |
| wds | input | 1 | Mode select: 0 normal, 1 extended (x128); any change restarts the timeout |
| base_period | input | PERIOD_W | Normal-mode timeout in clock cycles; 0 disables faults |
| hold_len | input | HOLD_W | Reset hold time in clock cycles; 0 acts as 1 |
| reset_n_o | output | 1 | Active-low reset to the processor |

## Verification
The bench sweeps the base period and the hold length, including a hold length of zero. A block with an off-by-one in the compare or in the hold counter would give a high or low time one cycle too long or too short. It measures the exact L+3 delay after a strobe drop and after a mode change in both directions. A block that missed the synchroniser latency, ignored one direction of mode change, or latched the limit from the old mode would give the wrong delay. It also changes the base period in the middle of a running timeout, and drives strobe and mode edges while reset is held. A block that reloaded the limit at once, or let edges during the hold disturb the counter, would change the measured times. Finally it runs a long stretch with the base period at zero to confirm that no fault occurs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Extended mode scales the timeout by 2**EXT_SHIFT.
  localparam int EXT_SHIFT = 7;

  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_EXTENDED = 1'b1
  } wdt_mode_e;
endpackage

// File: rtl/wdt_sync.sv
// Two-flop synchroniser plus one history stage per bit.
module wdt_sync #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] hist_q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= RST_VAL;
      stage_q <= RST_VAL;
      prev_q  <= RST_VAL;
    end else begin
      meta_q  <= din;
      stage_q <= meta_q;
      prev_q  <= stage_q;
    end
  end

  assign sync_q = stage_q;
  assign hist_q = prev_q;
endmodule

// File: rtl/wdt_timer.sv
// Timeout counter with the limit latched on every clear.
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int PERIOD_W = 16,
  localparam int CW      = PERIOD_W + EXT_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] base_i,
  input  wdt_mode_e           mode_i,
  input  logic                clear_i,
  output logic                fault_o,
  output logic [CW-1:0]       cnt_o,
  output logic [CW-1:0]       lim_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic [CW-1:0] eff_lim;
  logic          cnt_en;
  logic          armed;

  always_comb begin
    if (mode_i == MODE_EXTENDED) eff_lim = {base_i, {EXT_SHIFT{1'b0}}};
    else                         eff_lim = {{EXT_SHIFT{1'b0}}, base_i};
  end

  assign armed  = (lim_q != '0);
  assign cnt_en = clear_i | armed;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (clear_i) begin
      cnt_d = '0;
      lim_d = eff_lim;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign fault_o = armed & ~clear_i & (cnt_q == lim_q - CW'(1));
  assign cnt_o   = cnt_q;
  assign lim_o   = lim_q;
endmodule

// File: rtl/wdt_hold.sv
// Reset hold generator: asserted on power-on and on each fault.
module wdt_hold #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] len_i,
  input  logic              fault_i,
  output logic              active_o
);
  logic              active_q, active_d;
  logic [HOLD_W-1:0] elapsed_q, elapsed_d;
  logic              last_cycle;

  assign last_cycle = ({1'b0, elapsed_q} + (HOLD_W+1)'(1)) >= {1'b0, len_i};

  always_comb begin
    active_d  = active_q;
    elapsed_d = elapsed_q;
    if (active_q) begin
      if (last_cycle) begin
        active_d  = 1'b0;
        elapsed_d = '0;
      end else begin
        elapsed_d = elapsed_q + HOLD_W'(1);
      end
    end else if (fault_i) begin
      active_d  = 1'b1;
      elapsed_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b1;
      elapsed_q <= '0;
    end else begin
      active_q  <= active_d;
      elapsed_q <= elapsed_d;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int HOLD_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wdi,
  input  logic                wds,
  input  logic [PERIOD_W-1:0] base_period,
  input  logic [HOLD_W-1:0]   hold_len,
  output logic                reset_n_o
);
  localparam int CW = PERIOD_W + EXT_SHIFT;

  // bit 0: strobe (idles high), bit 1: mode select
  logic [1:0]    sync_lvl, sync_prev;
  logic          wdi_fall, wds_tog, wdt_clr, fault, hold_active;
  wdt_mode_e     mode;
  logic [CW-1:0] wdt_cnt, wdt_lim;

  wdt_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    ({wds, wdi}),
    .sync_q (sync_lvl),
    .hist_q (sync_prev)
  );

  assign wdi_fall = sync_prev[0] & ~sync_lvl[0];
  assign wds_tog  = sync_prev[1] ^ sync_lvl[1];
  assign mode     = sync_lvl[1] ? MODE_EXTENDED : MODE_NORMAL;
  assign wdt_clr  = hold_active | wdi_fall | wds_tog;

  wdt_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_i  (base_period),
    .mode_i  (mode),
    .clear_i (wdt_clr),
    .fault_o (fault),
    .cnt_o   (wdt_cnt),
    .lim_o   (wdt_lim)
  );

  wdt_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_i    (hold_len),
    .fault_i  (fault),
    .active_o (hold_active)
  );

  assign reset_n_o = ~hold_active;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reset_n_o,
  input logic          wdi_fall,
  input logic          wds_tog,
  input logic          wdt_clr,
  input logic [CW-1:0] wdt_cnt,
  input logic [CW-1:0] wdt_lim
);
  AST_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_n_o && wdt_lim != '0 && !wdt_clr && wdt_cnt == wdt_lim - CW'(1)) |=> !reset_n_o); // R1
  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wdi_fall |=> (wdt_cnt == '0)); // R2
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wds_tog |=> (wdt_cnt == '0)); // R3
  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_n_o |=> (wdt_cnt == '0)); // R4
  AST_COUNT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reset_n_o) && !wdt_clr && wdt_lim != '0) |=> (wdt_cnt == CW'(1))); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_n_o && wdt_lim == '0) |=> reset_n_o); // R7
  AST_LIMIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_clr |=> $stable(wdt_lim)); // R10
endmodule

bind wdt_top wdt_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reset_n_o (reset_n_o),
  .wdi_fall  (wdi_fall),
  .wds_tog   (wds_tog),
  .wdt_clr   (wdt_clr),
  .wdt_cnt   (wdt_cnt),
  .wdt_lim   (wdt_lim)
);

// File: tb/wdt_top_test.sv
module wdt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int HW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wdi;
  logic          wds;
  logic [PW-1:0] base_period;
  logic [HW-1:0] hold_len;
  logic          reset_n_o;

  int n_run  = 0;
  int n_fail = 0;

  wdt_top #(.PERIOD_W(PW), .HOLD_W(HW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdi         (wdi),
    .wds         (wds),
    .base_period (base_period),
    .hold_len    (hold_len),
    .reset_n_o   (reset_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until reset_n_o equals lvl.
  task automatic count_until(input logic lvl, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (reset_n_o == lvl || n >= 5000) break;
    end
  endtask

  // From anywhere: wait for a low phase, apply the settings, return at the first high negedge.
  task automatic set_cfg(input int b, input int l);
    int n;
    count_until(1'b0, n);
    base_period = PW'(b);
    hold_len    = HW'(l);
    count_until(1'b1, n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    int low_seen;
    rst_n = 1'b0; wdi = 1'b1; wds = 1'b0;
    base_period = PW'(10); hold_len = HW'(4);
    repeat (3) @(negedge clk);
    check(int'(reset_n_o), 0, "R9 reset state");
    rst_n = 1'b1;
    count_until(1'b1, n);
    check(n, 4, "R9 power-on hold");
    count_until(1'b0, n);
    check(n, 10, "R5 first timeout after release");

    // R1/R8 sweep over base period and hold length (now in a low phase)
    for (int b = 1; b <= 12; b++) begin
      for (int l = 0; l <= 5; l++) begin
        base_period = PW'(b);
        hold_len    = HW'(l);
        count_until(1'b1, n);
        count_until(1'b0, n);
        check(n, b, "R1 high time equals base");
        count_until(1'b1, n);
        check(n, (l == 0) ? 1 : l, "R8 hold length");
        count_until(1'b0, n);
      end
    end

    // R2 strobe drop delay
    set_cfg(10, 5);
    wdi = 1'b0;
    count_until(1'b0, n);
    check(n, 13, "R2 strobe clear delay");
    wdi = 1'b1;

    // R11 periodic strobing keeps reset high
    count_until(1'b1, n);
    low_seen = 0;
    for (int i = 0; i < 40; i++) begin
      wdi = 1'b0;
      repeat (3) begin @(negedge clk); if (!reset_n_o) low_seen++; end
      wdi = 1'b1;
      repeat (3) begin @(negedge clk); if (!reset_n_o) low_seen++; end
    end
    check(low_seen, 0, "R11 strobing holds off reset");

    // R3/R6 mode change up, then down
    set_cfg(10, 5);
    wds = 1'b1;
    count_until(1'b0, n);
    check(n, 1283, "R3 rising mode change delay");
    count_until(1'b1, n);
    count_until(1'b0, n);
    check(n, 1280, "R6 extended timeout");
    count_until(1'b1, n);
    wds = 1'b0;
    count_until(1'b0, n);
    check(n, 13, "R3 falling mode change delay");

    // R6 extended with base 2
    base_period = PW'(2);
    wds = 1'b1;
    count_until(1'b1, n);
    count_until(1'b0, n);
    check(n, 256, "R6 extended base 2");
    wds = 1'b0;
    base_period = PW'(10);
    count_until(1'b1, n);

    // R10 base change mid-count
    base_period = PW'(4);
    count_until(1'b0, n);
    check(n, 10, "R10 running timeout unchanged");
    count_until(1'b1, n);
    count_until(1'b0, n);
    check(n, 4, "R10 new base after clear");

    // R4 edges during the hold have no effect
    base_period = PW'(10);
    hold_len = HW'(6);
    count_until(1'b1, n);
    count_until(1'b0, n);
    wdi = 1'b0; wds = 1'b1;
    @(negedge clk);
    wdi = 1'b1;
    @(negedge clk);
    wds = 1'b0;
    count_until(1'b1, n);
    check(n + 2, 6, "R4 hold length with edges");
    count_until(1'b0, n);
    check(n, 10, "R4 timeout after edges in hold");

    // R7 base 0 disables faults
    base_period = PW'(0);
    count_until(1'b1, n);
    low_seen = 0;
    for (int i = 0; i < 3000; i++) begin
      if (i == 100) wds = 1'b1;
      if (i == 700) wds = 1'b0;
      if (i == 1200) wdi = 1'b0;
      if (i == 1210) wdi = 1'b1;
      @(negedge clk);
      if (!reset_n_o) low_seen++;
    end
    check(low_seen, 0, "R7 disabled watchdog stays quiet");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule